// File: doc/BRIEF.md
# Serial Stress Pattern Run Detector

This block monitors the recovered bit stream of a scrambled serial digital video link. It finds the two pathological bit shapes that a check-field test signal produces. The first is the cable-equalizer stressor: a run of nineteen identical bits closed by one bit of the other value. The second is the clock-recovery stressor: twenty zeros followed by twenty ones. Each bit arrives with a qualifying strobe. Every result is a registered pulse or level, so it can feed status or error logic directly.

Within a video line the block tracks whether the equalizer stressor repeats back to back, as it does once the scrambler locks into it, and raises a persistence level. At each line end it emits a one-cycle summary of the line. Per-field totals of both stressor classes are kept in saturating counters, which are latched and cleared at each field start. A word-end strobe marks 10-bit or 20-bit word boundaries. The boundary width depends on the selected rate.

Top module: `stress_run_detector`

## Requirements
- R1: An equalizer hit is a run of exactly 19 equal bits followed by a bit of the opposite value, for either polarity. It produces a one-cycle `eq_hit` pulse in the cycle after the closing bit is accepted.
- R2: A clock-recovery hit is a zero run of exactly 20 bits followed by ones. It produces a one-cycle `cr_hit` pulse after the twentieth one is accepted. A zero run of 21, or a ones run that ends at 19, gives no hit.
- R3: Run lengths saturate at 63. A run of 64 or more equal bits (for example 83) closed by the opposite bit never produces an equalizer hit.
- R4: `eq_persist` rises together with the eighth consecutive equalizer hit in a line. Hits are consecutive when each one lands exactly 20 accepted bits after the previous one. Seven hits, or eight hits with a broken chain, leave it low.
- R5: When a bit is accepted with `line_end` high, `line_eq_seen`, `line_cr_seen` and `line_eq_persist` pulse for one cycle. Each reports whether that event occurred in the line, including the line-end bit itself. In the same cycle `eq_persist` and the hit chain clear.
- R6: When a bit is accepted with `field_start` high, the per-field counts are copied to `field_eq_count` and `field_cr_count`. The counts then restart, and that bit's own hits count toward the new field. The outputs hold between field starts.
- R7: Per-field counts saturate at 2^CNT_W-1 (65535 by default) and never wrap.
- R8: `word_end` pulses after every 10th accepted bit when `hd_mode` is 0, and after every 20th when `hd_mode` is 1. The word position restarts at the bit following an accepted `line_end` bit.
- R9: Cycles with `bit_valid` low change no state, and every pulse output is low after them.
- R10: Synchronous active-high `rst` clears all run history, chains, flags, counts and outputs. A run started before reset never contributes to a hit afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies bit_in and the markers |
| bit_in | input | 1 | Recovered serial bit |
| hd_mode | input | 1 | 0: 10-bit words, 1: 20-bit words |
| line_end | input | 1 | Accepted bit is the last of its line |
| field_start | input | 1 | Accepted bit is the first of a field |
| eq_hit | output | 1 | Equalizer stressor detected |
| cr_hit | output | 1 | Clock-recovery stressor detected |
| word_end | output | 1 | Accepted bit closed a word |
| line_eq_seen | output | 1 | Line-end summary: equalizer hit in line |
| line_cr_seen | output | 1 | Line-end summary: clock-recovery hit in line |
| line_eq_persist | output | 1 | Line-end summary: persistence reached in line |
| eq_persist | output | 1 | Persistence level within the current line |
| field_eq_count | output | CNT_W | Equalizer hits in the last complete field |
| field_cr_count | output | CNT_W | Clock-recovery hits in the last complete field |

## Verification
Every result is registered once past the accepted bit. A hit, word-end or line summary for the bit taken at a rising edge is therefore visible right after that edge, and it is gone after the next edge. Likewise, latched field totals appear right after the field-start bit's edge. The bench applies each bit on the falling edge and reads outputs one nanosecond after the following rising edge. Each check thus tests the exact cycle a result is due, and pulse totals over a sequence catch any hit that comes early or late.

// File: rtl/stress_pkg.sv
package stress_pkg;

    localparam int RUN_W_DEF        = 6;
    localparam int EQ_RUN_DEF       = 19;
    localparam int CR_RUN_DEF       = 20;
    localparam int SD_WORD_DEF      = 10;
    localparam int HD_WORD_DEF      = 20;
    localparam int PERSIST_HITS_DEF = 8;
    localparam int CNT_W_DEF        = 16;

    typedef struct packed {
        logic eq;
        logic cr;
    } hit_t;

    typedef struct packed {
        logic eq_seen;
        logic cr_seen;
        logic persist;
    } line_sum_t;

endpackage

// File: rtl/srd_run_tracker.sv
module srd_run_tracker
    import stress_pkg::*;
#(
    parameter int RUN_W  = RUN_W_DEF,
    parameter int EQ_RUN = EQ_RUN_DEF,
    parameter int CR_RUN = CR_RUN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic bit_in,
    output hit_t hit
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [RUN_W-1:0] EQ_LEN  = RUN_W'(EQ_RUN);
    localparam logic [RUN_W-1:0] CR_LEN  = RUN_W'(CR_RUN);
    localparam logic [RUN_W-1:0] ONE     = RUN_W'(1);

    logic             have_prev;
    logic             prev_bit;
    logic [RUN_W-1:0] run_len;
    logic [RUN_W-1:0] zero_run;
    logic [RUN_W-1:0] run_next;
    logic             same;

    always_comb begin
        same = have_prev && (bit_in == prev_bit);
        if (same)
            run_next = (run_len == RUN_MAX) ? run_len : run_len + ONE;
        else
            run_next = ONE;
        hit.eq = valid && have_prev && !same && (run_len == EQ_LEN);
        hit.cr = valid && bit_in && (run_next == CR_LEN) && (zero_run == CR_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
            run_len   <= '0;
            zero_run  <= '0;
        end else if (valid) begin
            have_prev <= 1'b1;
            prev_bit  <= bit_in;
            run_len   <= run_next;
            if (have_prev && !prev_bit && bit_in)
                zero_run <= run_len;
        end
    end

endmodule

// File: rtl/srd_word_counter.sv
module srd_word_counter #(
    parameter int SD_WORD = stress_pkg::SD_WORD_DEF,
    parameter int HD_WORD = stress_pkg::HD_WORD_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic hd_mode,
    input  logic line_end,
    output logic word_last
);
    localparam int MAX_WORD = (SD_WORD > HD_WORD) ? SD_WORD : HD_WORD;
    localparam int POS_W    = $clog2(MAX_WORD);

    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] limit;
    logic             at_last;

    always_comb begin
        limit     = hd_mode ? POS_W'(HD_WORD - 1) : POS_W'(SD_WORD - 1);
        at_last   = (pos >= limit);
        word_last = valid && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (valid)
            pos <= (at_last || line_end) ? '0 : pos + POS_W'(1);
    end

endmodule

// File: rtl/srd_line_tracker.sv
module srd_line_tracker
    import stress_pkg::*;
#(
    parameter int RUN_W        = RUN_W_DEF,
    parameter int EQ_RUN       = EQ_RUN_DEF,
    parameter int PERSIST_HITS = PERSIST_HITS_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  logic      line_end,
    input  hit_t      hit,
    output line_sum_t summary,
    output logic      persist
);
    localparam int               STREAK_W   = $clog2(PERSIST_HITS + 1);
    localparam logic [RUN_W-1:0] GAP_MAX    = '1;
    localparam logic [RUN_W-1:0] CHAIN_GAP  = RUN_W'(EQ_RUN);
    localparam logic [STREAK_W-1:0] STK_MAX = '1;
    localparam logic [STREAK_W-1:0] STK_TOP = STREAK_W'(PERSIST_HITS);

    logic [RUN_W-1:0]    gap;
    logic [STREAK_W-1:0] streak;
    logic [STREAK_W-1:0] streak_next;
    logic                any_eq;
    logic                any_cr;
    logic                chained;
    logic                reach;

    always_comb begin
        chained = (streak != '0) && (gap == CHAIN_GAP);
        if (hit.eq)
            streak_next = chained ? ((streak == STK_MAX) ? streak : streak + STREAK_W'(1))
                                  : STREAK_W'(1);
        else
            streak_next = streak;
        reach = (streak_next >= STK_TOP);
        summary.eq_seen = valid && line_end && (any_eq || hit.eq);
        summary.cr_seen = valid && line_end && (any_cr || hit.cr);
        summary.persist = valid && line_end && (persist || reach);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap     <= GAP_MAX;
            streak  <= '0;
            any_eq  <= 1'b0;
            any_cr  <= 1'b0;
            persist <= 1'b0;
        end else if (valid) begin
            gap <= hit.eq ? '0 : ((gap == GAP_MAX) ? gap : gap + RUN_W'(1));
            if (line_end) begin
                streak  <= '0;
                any_eq  <= 1'b0;
                any_cr  <= 1'b0;
                persist <= 1'b0;
            end else begin
                streak  <= streak_next;
                any_eq  <= any_eq || hit.eq;
                any_cr  <= any_cr || hit.cr;
                persist <= persist || reach;
            end
        end
    end

endmodule

// File: rtl/srd_field_counter.sv
module srd_field_counter #(
    parameter int CNT_W = stress_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             field_start,
    input  logic             hit,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            total <= '0;
        end else if (valid) begin
            if (field_start) begin
                total <= count;
                count <= hit ? CNT_W'(1) : '0;
            end else if (hit && count != CNT_MAX) begin
                count <= count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/stress_run_detector.sv
module stress_run_detector
    import stress_pkg::*;
#(
    parameter int CNT_W        = CNT_W_DEF,
    parameter int RUN_W        = RUN_W_DEF,
    parameter int EQ_RUN       = EQ_RUN_DEF,
    parameter int CR_RUN       = CR_RUN_DEF,
    parameter int SD_WORD      = SD_WORD_DEF,
    parameter int HD_WORD      = HD_WORD_DEF,
    parameter int PERSIST_HITS = PERSIST_HITS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic             hd_mode,
    input  logic             line_end,
    input  logic             field_start,
    output logic             eq_hit,
    output logic             cr_hit,
    output logic             word_end,
    output logic             line_eq_seen,
    output logic             line_cr_seen,
    output logic             line_eq_persist,
    output logic             eq_persist,
    output logic [CNT_W-1:0] field_eq_count,
    output logic [CNT_W-1:0] field_cr_count
);
    localparam int N_CLASS = 2;

    hit_t             hit;
    line_sum_t        summary;
    logic             word_last;
    logic [N_CLASS-1:0] hit_vec;
    logic [CNT_W-1:0] totals [N_CLASS];

    srd_run_tracker #(
        .RUN_W (RUN_W),
        .EQ_RUN(EQ_RUN),
        .CR_RUN(CR_RUN)
    ) u_run (
        .clk   (clk),
        .rst   (rst),
        .valid (bit_valid),
        .bit_in(bit_in),
        .hit   (hit)
    );

    srd_word_counter #(
        .SD_WORD(SD_WORD),
        .HD_WORD(HD_WORD)
    ) u_word (
        .clk      (clk),
        .rst      (rst),
        .valid    (bit_valid),
        .hd_mode  (hd_mode),
        .line_end (line_end),
        .word_last(word_last)
    );

    srd_line_tracker #(
        .RUN_W       (RUN_W),
        .EQ_RUN      (EQ_RUN),
        .PERSIST_HITS(PERSIST_HITS)
    ) u_line (
        .clk     (clk),
        .rst     (rst),
        .valid   (bit_valid),
        .line_end(line_end),
        .hit     (hit),
        .summary (summary),
        .persist (eq_persist)
    );

    assign hit_vec = {hit.cr, hit.eq};

    for (genvar g = 0; g < N_CLASS; g++) begin : g_class
        srd_field_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk        (clk),
            .rst        (rst),
            .valid      (bit_valid),
            .field_start(field_start),
            .hit        (hit_vec[g]),
            .total      (totals[g])
        );
    end

    assign field_eq_count = totals[0];
    assign field_cr_count = totals[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_hit          <= 1'b0;
            cr_hit          <= 1'b0;
            word_end        <= 1'b0;
            line_eq_seen    <= 1'b0;
            line_cr_seen    <= 1'b0;
            line_eq_persist <= 1'b0;
        end else begin
            eq_hit          <= hit.eq;
            cr_hit          <= hit.cr;
            word_end        <= word_last;
            line_eq_seen    <= summary.eq_seen;
            line_cr_seen    <= summary.cr_seen;
            line_eq_persist <= summary.persist;
        end
    end

endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_valid,
    input logic             bit_in,
    input logic             line_end,
    input logic             field_start,
    input logic             eq_hit,
    input logic             cr_hit,
    input logic             word_end,
    input logic             line_eq_seen,
    input logic             line_cr_seen,
    input logic             line_eq_persist,
    input logic             eq_persist,
    input logic [CNT_W-1:0] field_eq_count,
    input logic [CNT_W-1:0] field_cr_count
);
    logic       vb1;
    logic       vb2;
    logic [1:0] nv;

    always_ff @(posedge clk) begin
        if (rst) begin
            vb1 <= 1'b0;
            vb2 <= 1'b0;
            nv  <= '0;
        end else if (bit_valid) begin
            vb2 <= vb1;
            vb1 <= bit_in;
            if (nv != 2'd2) nv <= nv + 2'd1;
        end
    end

    p_eq_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
        eq_hit |-> (nv == 2'd2) && (vb1 != vb2));

    p_cr_on_one_r2: assert property (@(posedge clk) disable iff (rst)
        cr_hit |-> (nv == 2'd2) && vb1 && vb2);

    p_persist_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(eq_persist) |-> eq_hit);

    p_persist_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(bit_valid && line_end) |-> !eq_persist);

    p_summary_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        (line_eq_seen || line_cr_seen || line_eq_persist) |-> $past(bit_valid && line_end));

    p_field_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_valid && field_start) |-> $stable(field_eq_count) && $stable(field_cr_count));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_valid) |-> !(eq_hit || cr_hit || word_end || line_eq_seen
                                || line_cr_seen || line_eq_persist));

    p_reset_clear_r10: assert property (@(posedge clk)
        $past(rst) |-> !eq_hit && !cr_hit && !eq_persist
                       && (field_eq_count == '0) && (field_cr_count == '0));

endmodule

bind stress_run_detector srd_checker #(.CNT_W(CNT_W)) u_srd_checker (
    .clk            (clk),
    .rst            (rst),
    .bit_valid      (bit_valid),
    .bit_in         (bit_in),
    .line_end       (line_end),
    .field_start    (field_start),
    .eq_hit         (eq_hit),
    .cr_hit         (cr_hit),
    .word_end       (word_end),
    .line_eq_seen   (line_eq_seen),
    .line_cr_seen   (line_cr_seen),
    .line_eq_persist(line_eq_persist),
    .eq_persist     (eq_persist),
    .field_eq_count (field_eq_count),
    .field_cr_count (field_cr_count)
);

// File: tb/test_stress_run_detector.sv
module test_stress_run_detector;

    localparam int CNT_W = 5;
    localparam int TBL_N = 7;
    localparam int RUN_TBL [TBL_N] = '{19, 19, 18, 20, 83, 64, 1};
    localparam bit POL_TBL [TBL_N] = '{0, 1, 0, 1, 0, 1, 0};
    localparam bit EXP_TBL [TBL_N] = '{1, 1, 0, 0, 0, 0, 0};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_valid = 1'b0;
    logic             bit_in = 1'b0;
    logic             hd_mode = 1'b0;
    logic             line_end = 1'b0;
    logic             field_start = 1'b0;
    logic             eq_hit, cr_hit, word_end;
    logic             line_eq_seen, line_cr_seen, line_eq_persist, eq_persist;
    logic [CNT_W-1:0] field_eq_count, field_cr_count;

    int tests = 0;
    int fails = 0;
    int acc_eq = 0;
    int acc_cr = 0;
    int acc_we = 0;
    int bit_idx = 0;
    int first_we = 0;

    always #2 clk = ~clk;

    stress_run_detector #(.CNT_W(CNT_W)) i_stress_run_detector (
        .clk            (clk),
        .rst            (rst),
        .bit_valid      (bit_valid),
        .bit_in         (bit_in),
        .hd_mode        (hd_mode),
        .line_end       (line_end),
        .field_start    (field_start),
        .eq_hit         (eq_hit),
        .cr_hit         (cr_hit),
        .word_end       (word_end),
        .line_eq_seen   (line_eq_seen),
        .line_cr_seen   (line_cr_seen),
        .line_eq_persist(line_eq_persist),
        .eq_persist     (eq_persist),
        .field_eq_count (field_eq_count),
        .field_cr_count (field_cr_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_acc();
        acc_eq = 0; acc_cr = 0; acc_we = 0; bit_idx = 0; first_we = 0;
    endtask

    task automatic send(input logic b, input logic le = 1'b0, input logic fs = 1'b0);
        @(negedge clk);
        bit_valid = 1'b1; bit_in = b; line_end = le; field_start = fs;
        @(posedge clk);
        #1;
        bit_valid = 1'b0; line_end = 1'b0; field_start = 1'b0;
        bit_idx++;
        acc_eq += int'(eq_hit);
        acc_cr += int'(cr_hit);
        if (word_end) begin
            acc_we++;
            if (first_we == 0) first_we = bit_idx;
        end
    endtask

    task automatic send_n(input logic b, input int n);
        for (int i = 0; i < n; i++) send(b);
    endtask

    task automatic eq_unit();
        send_n(1'b0, 19);
        send(1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_acc();
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int quiet;
        do_reset();
        // R10: reset state at the ports
        chk("R10 reset outputs", int'({eq_hit, cr_hit, word_end, line_eq_seen,
            line_cr_seen, line_eq_persist, eq_persist}), 0);
        chk("R10 reset counts", int'(field_eq_count) + int'(field_cr_count), 0);

        // Table: run of n bits of pol, closed by the opposite bit (R1, R3)
        for (int t = 0; t < TBL_N; t++) begin
            send(!POL_TBL[t]);
            clear_acc();
            send_n(POL_TBL[t], RUN_TBL[t]);
            send(!POL_TBL[t]);
            chk($sformatf("R1/R3 run %0d pol %0d eq pulses", RUN_TBL[t], POL_TBL[t]),
                acc_eq, int'(EXP_TBL[t]));
            chk($sformatf("R1 run %0d eq on closing bit", RUN_TBL[t]),
                int'(eq_hit), int'(EXP_TBL[t]));
        end

        // R2: 20 zeros then 20 ones
        do_reset();
        send(1'b1);
        send_n(1'b0, 20);
        send_n(1'b1, 19);
        chk("R2 no early cr", acc_cr, 0);
        send(1'b1);
        chk("R2 cr on 20th one", int'(cr_hit), 1);
        chk("R2 no eq in cr pattern", acc_eq, 0);
        // R5: line summary
        send(1'b0, 1'b1);
        chk("R5 line_cr_seen", int'(line_cr_seen), 1);
        chk("R5 line_eq_seen", int'(line_eq_seen), 0);
        // R2 negatives
        clear_acc();
        send_n(1'b0, 20);
        send_n(1'b1, 20);
        chk("R2 zero run 21 gives no cr", acc_cr, 0);
        send(1'b0);
        clear_acc();
        send_n(1'b0, 19);
        send_n(1'b1, 19);
        send(1'b0);
        chk("R2 ones run 19 gives no cr", acc_cr, 0);

        // R4: persistence after 8 chained hits
        do_reset();
        send(1'b1);
        for (int u = 0; u < 7; u++) eq_unit();
        chk("R4 seven hits", acc_eq, 7);
        chk("R4 no persist after 7", int'(eq_persist), 0);
        eq_unit();
        chk("R4 persist after 8th hit", int'(eq_persist), 1);
        send(1'b0, 1'b1);
        chk("R5 line_eq_persist", int'(line_eq_persist), 1);
        chk("R5 line_eq_seen", int'(line_eq_seen), 1);
        chk("R5 persist cleared at line end", int'(eq_persist), 0);
        send(1'b0);
        chk("R5 summary is one cycle", int'(line_eq_persist), 0);

        // R4: broken chain
        do_reset();
        send(1'b1);
        for (int u = 0; u < 4; u++) eq_unit();
        send(1'b1);
        for (int u = 0; u < 4; u++) eq_unit();
        chk("R4 broken chain hits", acc_eq, 8);
        chk("R4 broken chain no persist", int'(eq_persist), 0);

        // R6: field latch
        do_reset();
        send(1'b1, 1'b0, 1'b1);
        for (int u = 0; u < 3; u++) eq_unit();
        send_n(1'b0, 20);
        send_n(1'b1, 20);
        chk("R6 totals hold before field start", int'(field_eq_count), 0);
        send(1'b0, 1'b0, 1'b1);
        chk("R6 eq total", int'(field_eq_count), 3);
        chk("R6 cr total", int'(field_cr_count), 1);

        // R7: saturation at 31 with CNT_W=5
        for (int u = 0; u < 40; u++) eq_unit();
        send(1'b0, 1'b0, 1'b1);
        chk("R7 eq total saturates", int'(field_eq_count), 31);
        chk("R6 cr total restarted", int'(field_cr_count), 0);

        // R9: idle cycles do not advance the run
        do_reset();
        send(1'b1);
        send_n(1'b0, 10);
        quiet = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            bit_valid = 1'b0; bit_in = (i % 2 == 0); line_end = 1'b1;
            @(posedge clk);
            #1;
            quiet += int'(eq_hit) + int'(cr_hit) + int'(word_end) + int'(line_eq_seen);
        end
        line_end = 1'b0;
        chk("R9 idle pulses low", quiet, 0);
        send_n(1'b0, 9);
        send(1'b1);
        chk("R9 run spans idle cycles", int'(eq_hit), 1);

        // R10: reset forgets a partial run
        do_reset();
        send(1'b1);
        send_n(1'b0, 10);
        do_reset();
        send_n(1'b0, 9);
        send(1'b1);
        chk("R10 no hit across reset", acc_eq, 0);

        // R8: word boundaries
        do_reset();
        hd_mode = 1'b0;
        for (int i = 0; i < 25; i++) send(i[0]);
        chk("R8 sd word count", acc_we, 2);
        chk("R8 sd first word end", first_we, 10);
        do_reset();
        hd_mode = 1'b1;
        for (int i = 0; i < 40; i++) send(i[0]);
        chk("R8 hd word count", acc_we, 2);
        chk("R8 hd first word end", first_we, 20);
        do_reset();
        hd_mode = 1'b0;
        send_n(1'b1, 4);
        send(1'b0, 1'b1);
        clear_acc();
        for (int i = 0; i < 10; i++) send(i[0]);
        chk("R8 restart after line end", first_we, 10);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule